// File: doc/BRIEF.md
# Halfword-Swapping DMA Datapath

This block moves a buffer between a 16-bit peripheral stream and a byte-addressed memory port that carries one halfword per beat. A request names a start address, a byte length, a direction and a swap flag. The working address is the request address ORed with a base value that is held outside the block. The block then streams the data through, beat by beat, and pulses `done` when the last beat has been handed over.

In straight mode, bytes keep their lane and the address and length are used exactly as given. An odd length ends with a half-filled beat. In swap mode, bit 0 of both the address and the length is cleared first, and the two bytes of every halfword trade places in both directions. Data headed for memory is first gathered in a staging buffer of at most `CHUNK_BYTES` bytes and then written out as a burst. Data read from memory goes out one beat at a time, with one memory read outstanding.

Address translation, the register bank that holds the base value, and the peripheral itself are outside this block.

Top module: `dma_swap_path`

## Requirements
- R1: Every memory access uses the address `(req_addr | base_addr)`, with bit 0 cleared in swap mode. Beat k of a transfer goes to that address plus 2k.
- R2: In straight mode (`req_swap`=0), the peripheral byte on bits [7:0] maps to the lower memory address and the byte on bits [15:8] to the next one, in both directions. With an odd length, the last write beat has `mem_be`=2'b01. The last read beat has its bits [15:8] driven to zero.
- R3: In swap mode, length bit 0 is cleared, so a trailing odd byte is neither read nor written. Every memory beat then has an even address and `mem_be`=2'b11.
- R4: In swap mode, the two bytes of each halfword are exchanged between the peripheral side and the memory side, for both writes and reads.
- R5: In the write direction (`req_to_mem`=1), the transfer is cut into chunks of min(remaining, `CHUNK_BYTES`) bytes. No memory write of a chunk is issued before all of that chunk's peripheral beats have been accepted, and no peripheral beat is accepted while a chunk is being written out.
- R6: A request whose effective length is zero asserts `done` in the cycle after it is accepted and makes no memory access.
- R7: `mem_valid` with its address, write data, byte enables and direction, and `pout_valid` with `pout_data`, all hold steady until the matching ready is seen.
- R8: `req_ready` is high only while idle, and a request is taken when `req_valid` and `req_ready` are both high. `req_valid` during a transfer is ignored. `done` is a single-cycle pulse that follows the last memory or peripheral handshake, and `req_ready` returns in the cycle after it.
- R9: After reset, `req_ready` is 1 and `mem_valid`, `pin_ready`, `pout_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_addr | input | 32 | Value ORed into every request address |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | 32 | Start byte address |
| req_len | input | 16 | Length in bytes |
| req_to_mem | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| req_swap | input | 1 | 1: halfword swap mode with even rounding |
| pin_valid | input | 1 | Peripheral beat offered (write direction) |
| pin_ready | output | 1 | Peripheral beat taken |
| pin_data | input | 16 | Peripheral halfword |
| pout_valid | output | 1 | Beat for the peripheral (read direction) |
| pout_ready | input | 1 | Peripheral takes the beat |
| pout_data | output | 16 | Halfword for the peripheral |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | 32 | Byte address of the beat |
| mem_be | output | 2 | Byte enables, bit 0 for the lower address |
| mem_wdata | output | 16 | Write halfword |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 16 | Read halfword |
| done | output | 1 | One-cycle completion pulse |

## Verification
Most internal faults show up at the memory port within one beat. A mis-held swap flag flips byte order or leaves bit 0 set in `mem_addr`. A wrong running address shows as a gap or overlap between consecutive beat addresses. A miscounted remaining length shows as the wrong byte enable on the last beat, one beat too many or too few, or a `done` pulse that comes early, late or never. A staging-index fault shows only once the chunk is written out: the burst carries halfwords out of order or repeated, or starts before the peripheral has delivered the whole chunk.

// File: rtl/dmaswap_pkg.sv
package dmaswap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_DRAIN,
    ST_RREQ,
    ST_RWAIT,
    ST_ROUT,
    ST_DONE
  } xfer_st_e;
endpackage

// File: rtl/dma_req_prep.sv
module dma_req_prep #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_swap,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [LEN_W-1:0]  eff_len
);
  logic [ADDR_W-1:0] addr_clr;
  logic [LEN_W-1:0]  len_clr;

  // swap mode rounds both the start and the length down to even
  assign addr_clr = {{(ADDR_W-1){1'b1}}, ~req_swap};
  assign len_clr  = {{(LEN_W-1){1'b1}}, ~req_swap};

  always_comb begin
    eff_addr = (req_addr | base_addr) & addr_clr;
    eff_len  = req_len & len_clr;
  end
endmodule

// File: rtl/dma_byte_lane.sv
module dma_byte_lane #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic [BYTE_W*LANES-1:0] din,
  input  logic                    swap_en,
  input  logic                    keep_hi,
  output logic [BYTE_W*LANES-1:0] dout
);
  logic [BYTE_W*LANES-1:0] sel;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sel[g*BYTE_W +: BYTE_W] =
      swap_en ? din[(LANES-1-g)*BYTE_W +: BYTE_W] : din[g*BYTE_W +: BYTE_W];
  end

  // lanes above the lowest are zeroed on a half-filled final beat
  for (genvar g = 0; g < LANES; g++) begin : g_mask
    if (g == 0) begin : g_lo
      assign dout[g*BYTE_W +: BYTE_W] = sel[g*BYTE_W +: BYTE_W];
    end else begin : g_hi
      assign dout[g*BYTE_W +: BYTE_W] = keep_hi ? sel[g*BYTE_W +: BYTE_W] : '0;
    end
  end
endmodule

// File: rtl/dma_stage_buf.sv
module dma_stage_buf #(
  parameter int WORDS  = 32,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] store_q [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = store_q[rd_idx];
endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dmaswap_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int CHUNK_BYTES = 64,
  localparam int WORDS = CHUNK_BYTES / 2,
  localparam int IDX_W = $clog2(WORDS),
  localparam int BW    = IDX_W + 1,
  localparam int CW    = $clog2(CHUNK_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_to_mem,
  input  logic              req_swap,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [LEN_W-1:0]  eff_len,
  output logic              req_ready,
  input  logic              pin_valid,
  output logic              pin_ready,
  output logic              fill_wr,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [IDX_W-1:0]  drain_idx,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_be,
  input  logic              mem_rvalid,
  input  logic [15:0]       rd_lane,
  output logic              rd_keep_hi,
  output logic              pout_valid,
  input  logic              pout_ready,
  output logic [15:0]       pout_data,
  output logic              done,
  output logic              xfer_swap
);
  xfer_st_e          st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [CW-1:0]     chunk_q, chunk_d;
  logic [BW-1:0]     fill_q, fill_d;
  logic [BW-1:0]     drain_q, drain_d;
  logic              swap_q, swap_d;
  logic [15:0]       rd_q, rd_d;

  logic [BW-1:0]     beats;
  logic              fill_last;
  logic              drain_last;
  logic [LEN_W-1:0]  rem_after;
  logic [1:0]        rd_step;
  logic              rem_one;
  logic              rd_load;

  function automatic logic [CW-1:0] chunk_of(input logic [LEN_W-1:0] r);
    if (r > LEN_W'(CHUNK_BYTES)) return CW'(CHUNK_BYTES);
    return CW'(r);
  endfunction

  // derived per-chunk quantities
  always_comb begin
    beats      = BW'((chunk_q + CW'(1)) >> 1);
    fill_last  = (fill_q + BW'(1)) == beats;
    drain_last = (drain_q + BW'(1)) == beats;
    rem_after  = rem_q - LEN_W'(chunk_q);
    rem_one    = rem_q == LEN_W'(1);
    rd_step    = rem_one ? 2'd1 : 2'd2;
  end

  // next-state process
  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    chunk_d = chunk_q;
    fill_d  = fill_q;
    drain_d = drain_q;
    swap_d  = swap_q;
    rd_load = 1'b0;
    rd_d    = rd_lane;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          addr_d  = eff_addr;
          rem_d   = eff_len;
          swap_d  = req_swap;
          chunk_d = chunk_of(eff_len);
          fill_d  = '0;
          if (eff_len == '0)   st_d = ST_DONE;
          else if (req_to_mem) st_d = ST_FILL;
          else                 st_d = ST_RREQ;
        end
      end
      ST_FILL: begin
        if (pin_valid) begin
          fill_d = fill_q + BW'(1);
          if (fill_last) begin
            drain_d = '0;
            st_d    = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (mem_ready) begin
          drain_d = drain_q + BW'(1);
          if (drain_last) begin
            addr_d  = addr_q + ADDR_W'(chunk_q);
            rem_d   = rem_after;
            chunk_d = chunk_of(rem_after);
            fill_d  = '0;
            st_d    = (rem_after == '0) ? ST_DONE : ST_FILL;
          end
        end
      end
      ST_RREQ: begin
        if (mem_ready) st_d = ST_RWAIT;
      end
      ST_RWAIT: begin
        if (mem_rvalid) begin
          rd_load = 1'b1;
          st_d    = ST_ROUT;
        end
      end
      ST_ROUT: begin
        if (pout_ready) begin
          addr_d = addr_q + ADDR_W'(rd_step);
          rem_d  = rem_q - LEN_W'(rd_step);
          st_d   = (rem_q == LEN_W'(rd_step)) ? ST_DONE : ST_RREQ;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      chunk_q <= '0;
      fill_q  <= '0;
      drain_q <= '0;
      swap_q  <= 1'b0;
      rd_q    <= '0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      chunk_q <= chunk_d;
      fill_q  <= fill_d;
      drain_q <= drain_d;
      swap_q  <= swap_d;
      if (rd_load) begin
        rd_q <= rd_d;
      end
    end
  end

  // outputs
  always_comb begin
    req_ready  = st_q == ST_IDLE;
    pin_ready  = st_q == ST_FILL;
    fill_wr    = (st_q == ST_FILL) && pin_valid;
    fill_idx   = fill_q[IDX_W-1:0];
    drain_idx  = drain_q[IDX_W-1:0];
    mem_valid  = (st_q == ST_DRAIN) || (st_q == ST_RREQ);
    mem_we     = st_q == ST_DRAIN;
    if (st_q == ST_DRAIN) begin
      mem_addr = addr_q + ADDR_W'({drain_q, 1'b0});
      mem_be   = (drain_last && chunk_q[0]) ? 2'b01 : 2'b11;
    end else begin
      mem_addr = addr_q;
      mem_be   = rem_one ? 2'b01 : 2'b11;
    end
    rd_keep_hi = !rem_one;
    pout_valid = st_q == ST_ROUT;
    pout_data  = rd_q;
    done       = st_q == ST_DONE;
    xfer_swap  = swap_q;
  end
endmodule

// File: rtl/dma_swap_path.sv
module dma_swap_path #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int CHUNK_BYTES = 64,
  localparam int WORDS = CHUNK_BYTES / 2,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_to_mem,
  input  logic              req_swap,
  input  logic              pin_valid,
  output logic              pin_ready,
  input  logic [15:0]       pin_data,
  output logic              pout_valid,
  input  logic              pout_ready,
  output logic [15:0]       pout_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [15:0]       mem_rdata,
  output logic              done
);
  logic [ADDR_W-1:0] eff_addr;
  logic [LEN_W-1:0]  eff_len;
  logic              fill_wr;
  logic [IDX_W-1:0]  fill_idx;
  logic [IDX_W-1:0]  drain_idx;
  logic [15:0]       wr_lane;
  logic [15:0]       rd_lane;
  logic              rd_keep_hi;
  logic              xfer_swap;

  dma_req_prep #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_prep (
    .req_addr (req_addr),
    .base_addr(base_addr),
    .req_len  (req_len),
    .req_swap (req_swap),
    .eff_addr (eff_addr),
    .eff_len  (eff_len)
  );

  dma_byte_lane i_wr_lane (
    .din    (pin_data),
    .swap_en(xfer_swap),
    .keep_hi(1'b1),
    .dout   (wr_lane)
  );

  dma_byte_lane i_rd_lane (
    .din    (mem_rdata),
    .swap_en(xfer_swap),
    .keep_hi(rd_keep_hi),
    .dout   (rd_lane)
  );

  dma_stage_buf #(.WORDS(WORDS), .DATA_W(16)) i_buf (
    .clk    (clk),
    .wr_en  (fill_wr),
    .wr_idx (fill_idx),
    .wr_data(wr_lane),
    .rd_idx (drain_idx),
    .rd_data(mem_wdata)
  );

  dma_xfer_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CHUNK_BYTES(CHUNK_BYTES)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_to_mem(req_to_mem),
    .req_swap  (req_swap),
    .eff_addr  (eff_addr),
    .eff_len   (eff_len),
    .req_ready (req_ready),
    .pin_valid (pin_valid),
    .pin_ready (pin_ready),
    .fill_wr   (fill_wr),
    .fill_idx  (fill_idx),
    .drain_idx (drain_idx),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_rvalid(mem_rvalid),
    .rd_lane   (rd_lane),
    .rd_keep_hi(rd_keep_hi),
    .pout_valid(pout_valid),
    .pout_ready(pout_ready),
    .pout_data (pout_data),
    .done      (done),
    .xfer_swap (xfer_swap)
  );
endmodule

// File: rtl/dma_swap_path_chk.sv
module dma_swap_path_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              pin_ready,
  input logic              pout_valid,
  input logic              pout_ready,
  input logic [15:0]       pout_data,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        mem_be,
  input logic [15:0]       mem_wdata,
  input logic              done,
  input logic              xfer_swap
);
  // R7
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)
      && $stable(mem_be) && $stable(mem_wdata));

  // R7
  pout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pout_valid && !pout_ready |=> pout_valid && $stable(pout_data));

  // R3
  swap_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && xfer_swap |-> !mem_addr[0] && mem_be == 2'b11);

  // R5
  fill_drain_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ready |-> !mem_valid);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid && !pin_ready && !pout_valid && !done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);
endmodule

bind dma_swap_path dma_swap_path_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .pin_ready (pin_ready),
  .pout_valid(pout_valid),
  .pout_ready(pout_ready),
  .pout_data (pout_data),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .done      (done),
  .xfer_swap (xfer_swap)
);

// File: tb/test_dma_swap_path.sv
`timescale 1ns/1ps
module test_dma_swap_path;
  localparam int CH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base_addr = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic        req_to_mem = 1'b0;
  logic        req_swap = 1'b0;
  logic        pin_valid = 1'b0;
  logic        pin_ready;
  logic [15:0] pin_data;
  logic        pout_valid;
  logic        pout_ready = 1'b0;
  logic [15:0] pout_data;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata;
  logic        done;

  always #5 clk = ~clk;

  dma_swap_path i_dma_swap_path (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_to_mem(req_to_mem), .req_swap(req_swap),
    .pin_valid(pin_valid), .pin_ready(pin_ready), .pin_data(pin_data),
    .pout_valid(pout_valid), .pout_ready(pout_ready), .pout_data(pout_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done)
  );

  int n_chk = 0;
  int n_err = 0;

  // bench-side models and logs
  logic [15:0] src [128];
  logic [31:0] log_addr [256];
  logic [15:0] log_data [256];
  logic [1:0]  log_be   [256];
  logic [15:0] got      [256];
  int cyc = 0, pin_cnt = 0, wr_n = 0, got_n = 0, fires = 0, done_n = 0;
  int acc_cyc = 0, done_cyc = 0, last_fire = 0, order_bad = 0;
  int pin_base = 0, wr_base = 0, tot_beats = 0;
  logic [31:0] rd_addr = '0;
  bit pin_en = 0, stall_en = 0;

  function automatic logic [7:0] fbyte(input logic [31:0] a);
    logic [31:0] t;
    t = (a & 32'h3ff) * 7 + 3;
    return t[7:0];
  endfunction

  function automatic logic [15:0] sw16(input logic [15:0] d);
    return {d[7:0], d[15:8]};
  endfunction

  assign pin_data  = src[7'(pin_cnt - pin_base)];
  assign mem_rdata = {fbyte(rd_addr + 1), fbyte(rd_addr)};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pin_valid && pin_ready) pin_cnt <= pin_cnt + 1;
    mem_rvalid <= 1'b0;
    if (mem_valid && mem_ready) begin
      fires     <= fires + 1;
      last_fire <= cyc;
      if (mem_we) begin
        log_addr[wr_n % 256] <= mem_addr;
        log_data[wr_n % 256] <= mem_wdata;
        log_be[wr_n % 256]   <= mem_be;
        wr_n <= wr_n + 1;
        // R5: whole chunk gathered before its writes
        if ((pin_cnt - pin_base) !=
            ((((((wr_n - wr_base) * 2) / CH) + 1) * (CH / 2) < tot_beats) ?
             ((((wr_n - wr_base) * 2) / CH) + 1) * (CH / 2) : tot_beats))
          order_bad <= order_bad + 1;
      end else begin
        rd_addr    <= mem_addr;
        mem_rvalid <= 1'b1;
      end
    end
    if (pout_valid && pout_ready) begin
      got[got_n % 256] <= pout_data;
      got_n <= got_n + 1;
    end
    if (req_valid && req_ready) acc_cyc <= cyc;
    if (done) begin
      done_cyc <= cyc;
      done_n   <= done_n + 1;
    end
  end

  always @(negedge clk) begin
    mem_ready  <= !stall_en || ($urandom % 4 != 0);
    pout_ready <= !stall_en || ($urandom % 3 != 0);
    pin_valid  <= pin_en && (!stall_en || ($urandom % 3 != 0));
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] a, input int len, input bit to_mem,
                      input bit sw, input bit poke);
    logic [31:0] ea;
    int el, nb, d0, f0, g0, ob0, w, bad_k;
    logic [31:0] bad_a, exp_a;
    logic [15:0] bad_d, exp_d, dd;
    logic [1:0]  exp_be;
    bit addr_ok, data_ok, be_ok;
    ea = (a | base_addr) & (sw ? 32'hffff_fffe : 32'hffff_ffff);
    el = sw ? (len & ~1) : len;
    nb = (el + 1) / 2;
    for (int i = 0; i < 128; i++) src[i] = 16'($urandom);
    @(negedge clk);
    pin_base = pin_cnt; wr_base = wr_n; tot_beats = nb;
    d0 = done_n; f0 = fires; g0 = got_n; ob0 = order_bad;
    req_addr = a; req_len = 16'(len); req_to_mem = to_mem; req_swap = sw;
    pin_en = to_mem;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      if (done_n == d0) begin
        req_valid = 1'b1; req_len = 16'd3; req_to_mem = !to_mem; req_swap = !sw;
        check(req_ready == 1'b0, "R8", "req_ready while busy", 32'(req_ready), 0);
        @(negedge clk);
        req_valid = 1'b0;
      end
    end
    w = 0;
    while (done_n == d0 && w < 20000) begin @(negedge clk); w++; end
    pin_en = 0;
    check(done_n != d0, "R8", "done reached (watchdog)", 32'(done_n - d0), 1);
    repeat (4) @(negedge clk);
    check(done_n == d0 + 1, "R8", "single done per request", 32'(done_n - d0), 1);
    if (el == 0) begin
      check(fires == f0, "R6", "zero-length memory accesses", 32'(fires - f0), 0);
      check(done_cyc == acc_cyc + 1, "R6", "zero-length done latency",
            32'(done_cyc - acc_cyc), 1);
      return;
    end
    check(done_cyc > last_fire, "R8", "done after last beat",
          32'(done_cyc), 32'(last_fire));
    check(fires - f0 == nb, sw ? "R3" : "R2", "memory beat count", 32'(fires - f0), 32'(nb));
    addr_ok = 1; data_ok = 1; be_ok = 1; bad_k = 0;
    bad_a = '0; exp_a = '0; bad_d = '0; exp_d = '0;
    if (to_mem) begin
      check(order_bad == ob0, "R5", "writes before chunk filled", 32'(order_bad - ob0), 0);
      check(pin_cnt - pin_base == nb, "R5", "peripheral beats taken",
            32'(pin_cnt - pin_base), 32'(nb));
      for (int k = 0; k < nb; k++) begin
        dd = sw ? sw16(src[k]) : src[k];
        exp_be = (!sw && (el % 2 == 1) && k == nb - 1) ? 2'b01 : 2'b11;
        if (log_addr[(wr_base + k) % 256] != ea + 32'(2 * k) && addr_ok) begin
          addr_ok = 0; bad_a = log_addr[(wr_base + k) % 256]; exp_a = ea + 32'(2 * k);
        end
        if (exp_be == 2'b01) begin
          if (log_data[(wr_base + k) % 256][7:0] != dd[7:0] && data_ok) begin
            data_ok = 0; bad_d = log_data[(wr_base + k) % 256]; exp_d = dd;
          end
        end else if (log_data[(wr_base + k) % 256] != dd && data_ok) begin
          data_ok = 0; bad_d = log_data[(wr_base + k) % 256]; exp_d = dd; bad_k = k;
        end
        if (log_be[(wr_base + k) % 256] != exp_be) be_ok = 0;
      end
      check(be_ok, "R2", "write byte enables", 32'(be_ok), 1);
    end else begin
      check(got_n - g0 == nb, sw ? "R3" : "R2", "peripheral beats out", 32'(got_n - g0), 32'(nb));
      for (int k = 0; k < nb; k++) begin
        logic [31:0] ba;
        ba = ea + 32'(2 * k);
        dd = sw ? {fbyte(ba), fbyte(ba + 1)} : {fbyte(ba + 1), fbyte(ba)};
        if (!sw && (el % 2 == 1) && k == nb - 1) dd[15:8] = 8'h00;
        if (got[(g0 + k) % 256] != dd && data_ok) begin
          data_ok = 0; bad_d = got[(g0 + k) % 256]; exp_d = dd; bad_k = k;
        end
      end
      addr_ok = (rd_addr == ea + 32'(2 * (nb - 1)));
      bad_a = rd_addr; exp_a = ea + 32'(2 * (nb - 1));
    end
    check(addr_ok, "R1", "beat address", bad_a, exp_a);
    check(data_ok, sw ? "R4" : "R2", $sformatf("beat %0d data", bad_k), 32'(bad_d), 32'(exp_d));
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    // R9: reset values
    check(req_ready == 1'b1, "R9", "req_ready in reset", 32'(req_ready), 1);
    check({mem_valid, pin_ready, pout_valid, done} == 4'b0, "R9", "outputs in reset",
          32'({mem_valid, pin_ready, pout_valid, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && !mem_valid, "R9", "idle after reset",
          32'({req_ready, mem_valid}), 32'h2);

    // directed corners
    base_addr = 32'h0000_0100;
    xfer(32'h0000_0013, 7, 1, 0, 0);   // R2 odd straight write
    xfer(32'h0000_0013, 7, 1, 1, 0);   // R3/R4 odd rounded swap write
    xfer(32'h0000_0021, 1, 1, 1, 0);   // R6 rounds to zero
    xfer(32'h0000_0040, 0, 0, 0, 0);   // R6 zero straight read
    stall_en = 1;
    xfer(32'h0000_0002, 150, 1, 1, 1); // R5 chunks 64/64/22 plus busy poke
    xfer(32'h0000_0031, 130, 1, 0, 0); // R5 chunks 64/64/2
    xfer(32'h0000_0035, 5, 0, 0, 0);   // R2 odd straight read
    xfer(32'h0000_0047, 9, 0, 1, 1);   // R4 swap read, odd rounded
    // random mix
    for (int t = 0; t < 24; t++) begin
      base_addr = 32'($urandom % 4) << 8;
      stall_en  = ($urandom % 2) == 1;
      xfer(32'($urandom % 512), int'($urandom % 200), ($urandom % 2) == 1,
           ($urandom % 2) == 1, ($urandom % 4) == 0);
    end
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule